// File: doc/BRIEF.md
# I2C Clock Phase Generator with Stretch Feedback

This block times the serial clock of an I2C controller and tells the bit engine when to act. It drives the clock line low through an open-drain enable for a programmed count of cycles. It then releases the line and waits until a filtered copy of the line reads high. Only after that does it count out the high phase. A target that holds the clock low therefore stretches the bit for as long as it holds the line. The delay of the input filter also becomes part of the bit period.

The bit engine gets three strobes. The data-change strobe fires a programmed number of cycles into the low phase. The sample strobe fires at the middle of the high phase. The bit-end strobe marks the last cycle of the high phase. The engine holds its run request high for as long as it wants more bits. Byte framing, start and stop conditions are left to the engine. All pins are plain level or pulse signals, and none of them use a handshake.

Top module: `i2c_scl_gen`

## Requirements
- R1: During reset and after reset with run low, scl_oe_o, busy_o and all three strobes are 0 and scl_seen_o is 1.
- R2: With D = max(div_i, 1) and N = 2^filt_sel_i, each low phase drives scl_oe_o high for exactly L = max(D, N) consecutive cycles. The first such cycle follows the clock edge that samples run_i high while idle.
- R3: After the release, the high phase starts only once the filtered line has been seen low and then high. On an undisturbed line this waiting gap lasts N + 3 cycles.
- R4: A device that keeps the line low for S cycles beyond the release lengthens the waiting gap by exactly S cycles.
- R5: The high phase lasts D cycles, and bit_end_o pulses in its last cycle. With run_i held high, consecutive bits start L + N + 3 + D cycles apart.
- R6: sda_chg_o pulses exactly once per bit, in low-phase cycle min(sda_dly_i, L - 1), counting the first low cycle as 0.
- R7: sample_o pulses in high-phase cycle floor(D / 2), counting the first high cycle as 0.
- R8: scl_seen_o takes a new pin level only after that level has held for N consecutive samples at the output of the two-flop synchronizer. It changes at the (N + 2)-th rising clock edge after the pin changes, and a shorter excursion leaves it unchanged.
- R9: A bit that has started always completes. If run_i is low in the bit-end cycle, busy_o is 0 from the next cycle on.
- R10: div_i and filt_sel_i are captured at the edge that starts a bit. Changing them during a bit does not alter that bit's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Bit engine wants clock cycles while high |
| div_i | input | 16 | Length of each clock phase in cycles (0 acts as 1) |
| sda_dly_i | input | 8 | Cycles from the falling clock to the data-change strobe |
| filt_sel_i | input | 2 | Filter setting; a new level needs 2^setting stable samples |
| scl_in_i | input | 1 | Clock line as read at the pin |
| scl_oe_o | output | 1 | 1 pulls the clock line low, 0 releases it |
| scl_seen_o | output | 1 | Synchronized and filtered clock line level |
| busy_o | output | 1 | A bit is in progress |
| sda_chg_o | output | 1 | Pulse: the engine may change the data line now |
| sample_o | output | 1 | Pulse: the engine should sample the data line now |
| bit_end_o | output | 1 | Pulse: last cycle of the current bit |

## Verification
The hardest case to reach is a release that the line does not follow. The bench models the open-drain wire as a wired AND of the block's enable and its own pull-down. It keeps that pull-down asserted for a chosen number of cycles past the release, so that the wait gap can be measured against N + 3 + S. Another hard case is a setting where the filter is slower than the divider. Here the low phase has to stretch, or the feedback edge would be filtered away. The bench covers this with a divider of 2 under the longest filter setting. It also drives a pin excursion one sample shorter than the filter threshold while the block is idle.

// File: rtl/i2c_scl_pkg.sv
`timescale 1ns/1ps
package i2c_scl_pkg;

  // Phase of the generated clock; LOW drives the line, the others release it.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;

endpackage

// File: rtl/i2c_scl_filter.sv
`timescale 1ns/1ps
module i2c_scl_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             level_o
);

  localparam int MAX_SAMPLES = 1 << ((1 << SEL_W) - 1);
  localparam int CNT_W       = $clog2(MAX_SAMPLES);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   synced;
  logic [CNT_W-1:0]       agree_cnt_q;
  logic [CNT_W-1:0]       limit;
  logic                   level_q;

  // Synchronizer chain, idle-high after reset.
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b1;
        else        sync_q[g] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b1;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign synced = sync_q[SYNC_STAGES-1];
  assign limit  = CNT_W'((1 << sel_i) - 1);

  // Count consecutive samples that disagree with the held level.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q     <= 1'b1;
      agree_cnt_q <= '0;
    end else if (synced == level_q) begin
      agree_cnt_q <= '0;
    end else if (agree_cnt_q == limit) begin
      level_q     <= synced;
      agree_cnt_q <= '0;
    end else begin
      agree_cnt_q <= agree_cnt_q + CNT_W'(1);
    end
  end

  assign level_o = level_q;

  // R8: the filtered level only moves to a value the synchronizer presented.
  p_level_follows_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |-> ($past(synced) == level_q));

endmodule

// File: rtl/i2c_scl_phase.sv
`timescale 1ns/1ps
module i2c_scl_phase
  import i2c_scl_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FILT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [FILT_W-1:0] filt_i,
  input  logic              line_hi_i,
  output scl_phase_e        phase_o,
  output logic [DIV_W-1:0]  cnt_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [DIV_W-1:0]  low_len_o,
  output logic [FILT_W-1:0] filt_o
);

  scl_phase_e        phase_q, phase_d;
  logic [DIV_W-1:0]  cnt_q, cnt_d;
  logic [DIV_W-1:0]  div_q, low_len_q;
  logic [FILT_W-1:0] filt_q;
  logic [DIV_W-1:0]  div_in, samples_in, low_in;
  logic              lo_seen_q;
  logic              low_done, high_done, load_cfg;

  // Effective divider and low-phase floor from the live settings.
  always_comb begin
    div_in     = (div_i == '0) ? DIV_W'(1) : div_i;
    samples_in = DIV_W'(1) << filt_i;
    low_in     = (div_in > samples_in) ? div_in : samples_in;
  end

  assign low_done  = (phase_q == PH_LOW)  && (cnt_q == low_len_q - DIV_W'(1));
  assign high_done = (phase_q == PH_HIGH) && (cnt_q == div_q - DIV_W'(1));
  assign load_cfg  = (phase_q == PH_IDLE) || (high_done && run_i);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q + DIV_W'(1);
    unique case (phase_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (run_i) phase_d = PH_LOW;
      end
      PH_LOW: begin
        if (low_done) begin
          phase_d = PH_WAIT;
          cnt_d   = '0;
        end
      end
      PH_WAIT: begin
        cnt_d = '0;
        if (lo_seen_q && line_hi_i) phase_d = PH_HIGH;
      end
      PH_HIGH: begin
        if (high_done) begin
          phase_d = run_i ? PH_LOW : PH_IDLE;
          cnt_d   = '0;
        end
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      lo_seen_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      if (phase_d == PH_LOW && phase_q != PH_LOW) lo_seen_q <= 1'b0;
      else if (!line_hi_i)                          lo_seen_q <= 1'b1;
    end
  end

  // Settings are frozen for the duration of a bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q     <= DIV_W'(1);
      low_len_q <= DIV_W'(1);
      filt_q    <= '0;
    end else if (load_cfg) begin
      div_q     <= div_in;
      low_len_q <= low_in;
      filt_q    <= filt_i;
    end
  end

  assign phase_o   = phase_q;
  assign cnt_o     = cnt_q;
  assign div_o     = div_q;
  assign low_len_o = low_len_q;
  assign filt_o    = filt_q;

  // R3: the high phase is entered only with the filtered line high.
  p_high_after_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HIGH && $past(phase_q) == PH_WAIT) |-> $past(line_hi_i));

  // R4: while the line reads low after release, the phase keeps waiting.
  p_wait_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WAIT && !line_hi_i) |=> (phase_q == PH_WAIT));

  // R2: the low phase ends only at its programmed length.
  p_low_length_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WAIT && $past(phase_q) == PH_LOW)
      |-> ($past(cnt_q) + DIV_W'(1) == $past(low_len_q)));

  // R10: the captured divider does not move inside a bit.
  p_div_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && $past(phase_q) != PH_IDLE && $past(phase_q) != PH_HIGH)
      |-> $stable(div_q));

endmodule

// File: rtl/i2c_scl_strobes.sv
`timescale 1ns/1ps
module i2c_scl_strobes
  import i2c_scl_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  scl_phase_e       phase_i,
  input  logic [DIV_W-1:0] cnt_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [DIV_W-1:0] low_len_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             scl_oe_o,
  output logic             sda_chg_o,
  output logic             sample_o,
  output logic             bit_end_o
);

  logic [DIV_W-1:0] dly_ext, chg_at, sample_at;

  always_comb begin
    dly_ext   = DIV_W'(dly_i);
    chg_at    = (dly_ext < low_len_i) ? dly_ext : (low_len_i - DIV_W'(1));
    sample_at = div_i >> 1;
  end

  assign scl_oe_o  = (phase_i == PH_LOW);
  assign sda_chg_o = (phase_i == PH_LOW)  && (cnt_i == chg_at);
  assign sample_o  = (phase_i == PH_HIGH) && (cnt_i == sample_at);
  assign bit_end_o = (phase_i == PH_HIGH) && (cnt_i == div_i - DIV_W'(1));

  // R6 / R7: the data-change and sample strobes never coincide.
  p_strobes_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sda_chg_o, sample_o}));

  // R5: a bit ends with the line released.
  p_end_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end_o |-> !scl_oe_o);

endmodule

// File: rtl/i2c_scl_gen.sv
`timescale 1ns/1ps
module i2c_scl_gen
  import i2c_scl_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int DLY_W       = 8,
  parameter int FILT_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [DLY_W-1:0]  sda_dly_i,
  input  logic [FILT_W-1:0] filt_sel_i,
  input  logic              scl_in_i,
  output logic              scl_oe_o,
  output logic              scl_seen_o,
  output logic              busy_o,
  output logic              sda_chg_o,
  output logic              sample_o,
  output logic              bit_end_o
);

  scl_phase_e        phase;
  logic [DIV_W-1:0]  cnt, div_eff, low_len;
  logic [FILT_W-1:0] filt_eff;
  logic              line_hi;

  i2c_scl_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .SEL_W      (FILT_W)
  ) u_filter (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (scl_in_i),
    .sel_i  (filt_eff),
    .level_o(line_hi)
  );

  i2c_scl_phase #(
    .DIV_W (DIV_W),
    .FILT_W(FILT_W)
  ) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run_i),
    .div_i    (div_i),
    .filt_i   (filt_sel_i),
    .line_hi_i(line_hi),
    .phase_o  (phase),
    .cnt_o    (cnt),
    .div_o    (div_eff),
    .low_len_o(low_len),
    .filt_o   (filt_eff)
  );

  i2c_scl_strobes #(
    .DIV_W(DIV_W),
    .DLY_W(DLY_W)
  ) u_strobes (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase_i  (phase),
    .cnt_i    (cnt),
    .div_i    (div_eff),
    .low_len_i(low_len),
    .dly_i    (sda_dly_i),
    .scl_oe_o (scl_oe_o),
    .sda_chg_o(sda_chg_o),
    .sample_o (sample_o),
    .bit_end_o(bit_end_o)
  );

  assign scl_seen_o = line_hi;
  assign busy_o     = (phase != PH_IDLE);

  // R9: leaving a bit without run returns to idle.
  p_idle_after_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end_o && !run_i) |=> !busy_o);

endmodule

// File: tb/i2c_scl_gen_bench.sv
`timescale 1ns/1ps
module i2c_scl_gen_bench;

  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [15:0] div_cfg = 16'd6;
  logic [7:0]  dly_cfg = 8'd0;
  logic [1:0]  filt_cfg = 2'd0;
  logic        ext_low = 1'b0;
  logic        scl_pin;
  logic        scl_oe, scl_seen, busy, sda_chg, sample, bit_end;

  int n_checks = 0;
  int n_errors = 0;

  int m_lo0, m_rel, m_chg, m_smp, m_bend, m_lo1, m_nchg;

  always #(CLK_NS/2) clk = ~clk;

  assign scl_pin = ~scl_oe & ~ext_low;

  i2c_scl_gen u_i2c_scl_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run),
    .div_i     (div_cfg),
    .sda_dly_i (dly_cfg),
    .filt_sel_i(filt_cfg),
    .scl_in_i  (scl_pin),
    .scl_oe_o  (scl_oe),
    .scl_seen_o(scl_seen),
    .busy_o    (busy),
    .sda_chg_o (sda_chg),
    .sample_o  (sample),
    .bit_end_o (bit_end)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int eff_div(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  function automatic int low_len(input int d, input int f);
    int n = 1 << f;
    return (eff_div(d) > n) ? eff_div(d) : n;
  endfunction

  // Runs one bit (or up to the start of a second) and records cycle indexes.
  task automatic measure(input int stretch, input bit two_bits, input bit drop_mid, input bit change_div);
    m_lo0 = -1; m_rel = -1; m_chg = -1; m_smp = -1; m_bend = -1; m_lo1 = -1; m_nchg = 0;
    run = 1'b1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (m_lo0 < 0) begin
        if (scl_oe) begin
          m_lo0 = k;
          if (stretch > 0) ext_low = 1'b1;
        end
      end else if (m_rel < 0 && !scl_oe) begin
        m_rel = k;
      end
      if (m_rel >= 0 && stretch > 0 && k == m_rel + stretch) ext_low = 1'b0;
      if (m_lo0 >= 0 && k == m_lo0 + 1) begin
        if (drop_mid)   run = 1'b0;
        if (change_div) div_cfg = 16'd20;
      end
      if (sda_chg) begin
        m_nchg++;
        if (m_chg < 0) m_chg = k;
      end
      if (sample && m_smp < 0) m_smp = k;
      if (bit_end && m_bend < 0) begin
        m_bend = k;
        if (!two_bits) begin
          run = 1'b0;
          break;
        end
      end else if (two_bits && m_bend >= 0 && scl_oe) begin
        m_lo1 = k;
        run = 1'b0;
        break;
      end
    end
  endtask

  task automatic check_bit(input string tag, input int d, input int f, input int dly, input int s);
    int dd = eff_div(d);
    int ll = low_len(d, f);
    int hi_start = m_bend - (dd - 1);
    check({"R2 ", tag}, "low length", m_rel - m_lo0, ll);
    check({"R6 ", tag}, "data change index", m_chg - m_lo0, (dly < ll - 1) ? dly : ll - 1);
    check({"R3 R4 ", tag}, "wait gap", hi_start - m_rel, (1 << f) + 3 + s);
    check({"R7 ", tag}, "sample to end", m_bend - m_smp, dd - 1 - dd / 2);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 2000; k++) begin
      if (!busy) break;
      @(negedge clk);
    end
    ext_low = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1", "scl_oe in reset", scl_oe, 0);
    check("R1", "busy in reset", busy, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "scl_oe idle", scl_oe, 0);
    check("R1", "busy idle", busy, 0);
    check("R1", "seen idle", scl_seen, 1);
    check("R1", "strobes idle", {sda_chg, sample, bit_end}, 0);
  endtask

  task automatic t_basic();
    div_cfg = 16'd6; dly_cfg = 8'd2; filt_cfg = 2'd0;
    measure(0, 1'b0, 1'b0, 1'b0);
    check_bit("basic", 6, 0, 2, 0);
    check("R6", "one change strobe", m_nchg, 1);
    @(negedge clk);
    check("R9", "idle after end", busy, 0);
    wait_idle();
  endtask

  task automatic t_two_bits();
    div_cfg = 16'd5; dly_cfg = 8'd1; filt_cfg = 2'd1;
    measure(0, 1'b1, 1'b0, 1'b0);
    check("R5", "bit period", m_lo1 - m_lo0, 5 + 2 + 3 + 5);
    check("R2", "low length two bits", m_rel - m_lo0, 5);
    wait_idle();
  endtask

  task automatic t_stretch();
    div_cfg = 16'd4; dly_cfg = 8'd0; filt_cfg = 2'd0;
    measure(7, 1'b0, 1'b0, 1'b0);
    check_bit("stretch", 4, 0, 0, 7);
    wait_idle();
  endtask

  task automatic t_filter_floor();
    div_cfg = 16'd2; dly_cfg = 8'd0; filt_cfg = 2'd3;
    measure(0, 1'b0, 1'b0, 1'b0);
    check_bit("filter floor", 2, 3, 0, 0);
    wait_idle();
  endtask

  task automatic t_delay_clamp();
    div_cfg = 16'd5; dly_cfg = 8'd200; filt_cfg = 2'd0;
    measure(0, 1'b0, 1'b0, 1'b0);
    check_bit("delay clamp", 5, 0, 200, 0);
    wait_idle();
  endtask

  task automatic t_div_zero();
    div_cfg = 16'd0; dly_cfg = 8'd0; filt_cfg = 2'd0;
    measure(0, 1'b0, 1'b0, 1'b0);
    check_bit("div zero", 0, 0, 0, 0);
    wait_idle();
  endtask

  task automatic t_cfg_change();
    div_cfg = 16'd6; dly_cfg = 8'd1; filt_cfg = 2'd0;
    measure(0, 1'b0, 1'b0, 1'b1);
    check_bit("R10 config held", 6, 0, 1, 0);
    div_cfg = 16'd6;
    wait_idle();
  endtask

  task automatic t_drop_mid();
    div_cfg = 16'd3; dly_cfg = 8'd0; filt_cfg = 2'd0;
    measure(0, 1'b0, 1'b1, 1'b0);
    check("R9", "bit completes after drop", (m_bend >= 0) ? 1 : 0, 1);
    @(negedge clk);
    check("R9", "idle after dropped bit", busy, 0);
    wait_idle();
  endtask

  task automatic t_glitch();
    int lows = 0;
    filt_cfg = 2'd2;
    repeat (4) @(negedge clk);
    ext_low = 1'b1;
    repeat (3) @(negedge clk);
    ext_low = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (!scl_seen) lows++;
    end
    check("R8", "short glitch rejected", lows, 0);
    ext_low = 1'b1;
    repeat (5) @(negedge clk);
    check("R8", "level before threshold", scl_seen, 1);
    @(negedge clk);
    check("R8", "level at threshold", scl_seen, 0);
    ext_low = 1'b0;
    repeat (10) @(negedge clk);
    check("R8", "level back high", scl_seen, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_two_bits();
    t_stretch();
    t_filter_floor();
    t_delay_clamp();
    t_div_zero();
    t_cfg_change();
    t_drop_mid();
    t_glitch();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule